// File: doc/BRIEF.md
# Gate-Level Signed/Unsigned Adder-Subtractor with Status Flags

This block adds or subtracts two 16-bit operands in one combinational pass. An operation input picks addition or subtraction. A mode input says whether the operands are plain binary magnitudes or two's-complement signed values. The sum does not depend on the mode. The mode only decides which status flag can mark the result as unusable: unsigned carry, unsigned borrow, or signed overflow.

The datapath uses only small gate modules: two-input AND, OR and XOR, and an inverter. The XOR module is itself built from AND, OR and inverter instances. These gates form half adders. Two half adders and an OR gate form a full adder. Full adders chain into 4-bit ripple slices, and the slices chain into the full-width ripple adder.

To subtract, every bit of the second operand passes through an XOR with the operation bit. The operation bit is also the carry into the least significant position. No arithmetic, shift or concatenation operator appears in the datapath, and no procedural block appears in it either.

Top module: `addsub_flags`

## Requirements
- R1: With `op_sub_i` = 0 (add), `res_o` equals the low 16 bits of `a_i + b_i`, and this holds in both modes.
- R2: With `op_sub_i` = 1 (subtract), `res_o` equals `a_i - b_i` modulo 65536, that is, `a_i + ~b_i + 1`.
- R3: `carry_o` is 1 exactly when `signed_i` = 0, `op_sub_i` = 0 and the true sum `a_i + b_i` exceeds 65535. In all other cases it is 0.
- R4: `borrow_o` is 1 exactly when `signed_i` = 0, `op_sub_i` = 1 and `a_i` < `b_i` as unsigned numbers. In all other cases it is 0.
- R5: `ovf_o` is 1 exactly when `signed_i` = 1 and the true signed result of the selected operation lies outside -32768 to 32767. In all other cases it is 0.
- R6: `valid_o` is 1 exactly when none of `carry_o`, `borrow_o` and `ovf_o` is set, so at most one of those three flags is ever high.
- R7: For the same operands and operation, changing `signed_i` leaves `res_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand (minuend when subtracting) |
| b_i | input | 16 | Second operand (subtrahend when subtracting) |
| op_sub_i | input | 1 | 0 = add, 1 = subtract |
| signed_i | input | 1 | 0 = operands unsigned, 1 = operands two's-complement signed |
| res_o | output | 16 | Sum or difference, modulo 2^16 |
| carry_o | output | 1 | Unsigned addition carried out of the top bit |
| borrow_o | output | 1 | Unsigned subtraction needed a borrow |
| ovf_o | output | 1 | Signed result out of range |
| valid_o | output | 1 | Result is representable in the selected mode |

## Verification
The assertions in the top module compare the result with a behavioural sum and difference whenever the inputs change. They also check each flag against an operand comparison or a sign-pattern rule that is independent of the carry chain, and they check that the three flags are mutually exclusive. Some behaviour can only be shown by the bench's scenarios. These include the fixed directed pairs at the edges of the range, such as 0 - 1, 0xFFFF + 1, 0x7FFF + 1 signed and 0x8000 - 1 signed, and the signed-overflow cases in the directed list. They also include the claim that flipping the mode between two evaluations leaves the sum untouched, and the match against an integer reference model over a fixed-seed random set in both modes.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned SLICE_W = 4;
endpackage

// File: rtl/addsub_gates.sv
module gate_and2 (
  input  logic x,
  input  logic y,
  output logic z
);
  assign z = x & y;
endmodule

module gate_or2 (
  input  logic x,
  input  logic y,
  output logic z
);
  assign z = x | y;
endmodule

module gate_inv (
  input  logic x,
  output logic z
);
  assign z = ~x;
endmodule

// Exclusive OR composed from the three primitive gates: (x & ~y) | (~x & y)
module gate_xor2 (
  input  logic x,
  input  logic y,
  output logic z
);
  logic nx, ny, t0, t1;
  gate_inv  u_nx (.x(x),  .z(nx));
  gate_inv  u_ny (.x(y),  .z(ny));
  gate_and2 u_t0 (.x(x),  .y(ny), .z(t0));
  gate_and2 u_t1 (.x(nx), .y(y),  .z(t1));
  gate_or2  u_z  (.x(t0), .y(t1), .z(z));
endmodule

// File: rtl/addsub_cells.sv
module half_add (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  gate_xor2 u_s (.x(x), .y(y), .z(s));
  gate_and2 u_c (.x(x), .y(y), .z(c));
endmodule

module full_add (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic s0, c0, c1;
  half_add u_h0 (.x(x),  .y(y),  .s(s0), .c(c0));
  half_add u_h1 (.x(s0), .y(ci), .s(s),  .c(c1));
  gate_or2 u_co (.x(c0), .y(c1), .z(co));
endmodule

module ripple_slice #(
  parameter int unsigned W = addsub_pkg::SLICE_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] cc;
  assign cc[0] = ci;
  for (genvar i = 0; i < W; i++) begin : g_bit
    full_add u_fa (.x(x[i]), .y(y[i]), .ci(cc[i]), .s(s[i]), .co(cc[i+1]));
  end
  assign co = cc[W];
endmodule

module ripple_adder #(
  parameter int unsigned WIDTH = addsub_pkg::DATA_W,
  parameter int unsigned SLICE = addsub_pkg::SLICE_W
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             ci,
  output logic [WIDTH-1:0] s,
  output logic             co
);
  localparam int unsigned NSL = WIDTH / SLICE;
  logic [NSL:0] sc;
  assign sc[0] = ci;
  for (genvar k = 0; k < NSL; k++) begin : g_slice
    ripple_slice #(.W(SLICE)) u_sl (
      .x (x[k*SLICE +: SLICE]),
      .y (y[k*SLICE +: SLICE]),
      .ci(sc[k]),
      .s (s[k*SLICE +: SLICE]),
      .co(sc[k+1])
    );
  end
  assign co = sc[NSL];
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int unsigned WIDTH = addsub_pkg::DATA_W,
  parameter int unsigned SLICE = addsub_pkg::SLICE_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             op_sub_i,
  input  logic             signed_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             borrow_o,
  output logic             ovf_o,
  output logic             valid_o
);
  localparam int unsigned MSB = WIDTH - 1;

  // conditional inversion of the second operand
  logic [WIDTH-1:0] b_eff;
  for (genvar i = 0; i < WIDTH; i++) begin : g_binv
    gate_xor2 u_bx (.x(b_i[i]), .y(op_sub_i), .z(b_eff[i]));
  end

  logic cout;
  ripple_adder #(.WIDTH(WIDTH), .SLICE(SLICE)) u_add (
    .x(a_i), .y(b_eff), .ci(op_sub_i), .s(res_o), .co(cout)
  );

  // carry into the top bit recovered from the top sum bit: c = s ^ a ^ b
  logic ab_top, c_msb, ovf_raw;
  gate_xor2 u_ab  (.x(a_i[MSB]), .y(b_eff[MSB]), .z(ab_top));
  gate_xor2 u_cm  (.x(res_o[MSB]), .y(ab_top), .z(c_msb));
  gate_xor2 u_ovf (.x(c_msb), .y(cout), .z(ovf_raw));

  logic n_sgn, n_sub, n_cout, uns_add, uns_sub, any_cb, any_flag;
  gate_inv  u_nsg (.x(signed_i), .z(n_sgn));
  gate_inv  u_nsb (.x(op_sub_i), .z(n_sub));
  gate_inv  u_nco (.x(cout),     .z(n_cout));
  gate_and2 u_ua  (.x(n_sgn), .y(n_sub),    .z(uns_add));
  gate_and2 u_us  (.x(n_sgn), .y(op_sub_i), .z(uns_sub));
  gate_and2 u_cf  (.x(uns_add), .y(cout),   .z(carry_o));
  gate_and2 u_bf  (.x(uns_sub), .y(n_cout), .z(borrow_o));
  gate_and2 u_of  (.x(signed_i), .y(ovf_raw), .z(ovf_o));
  gate_or2  u_o1  (.x(carry_o), .y(borrow_o), .z(any_cb));
  gate_or2  u_o2  (.x(any_cb),  .y(ovf_o),    .z(any_flag));
  gate_inv  u_vld (.x(any_flag), .z(valid_o));

  // behavioural cross-checks, independent of the gate network
  logic [WIDTH:0] ref_add, ref_sub;
  logic           b_top_eff, ovf_sign_rule;
  always_comb begin
    ref_add       = (WIDTH+1)'(a_i) + (WIDTH+1)'(b_i);
    ref_sub       = (WIDTH+1)'(a_i) - (WIDTH+1)'(b_i);
    b_top_eff     = op_sub_i ? !b_i[MSB] : b_i[MSB];
    ovf_sign_rule = (a_i[MSB] == b_top_eff) && (res_o[MSB] != a_i[MSB]);
    if (!op_sub_i) begin
      AST_ADD_SUM: assert (res_o == ref_add[WIDTH-1:0]) else $error("add sum mismatch"); // R1
    end
    if (op_sub_i) begin
      AST_SUB_DIFF: assert (res_o == ref_sub[WIDTH-1:0]) else $error("sub diff mismatch"); // R2
    end
    if (!signed_i && !op_sub_i) begin
      AST_UNS_CARRY: assert (carry_o == ref_add[WIDTH]) else $error("carry flag wrong"); // R3
    end
    if (!signed_i && op_sub_i) begin
      AST_UNS_BORROW: assert (borrow_o == (a_i < b_i)) else $error("borrow flag wrong"); // R4
    end
    if (signed_i) begin
      AST_SGN_OVF: assert (ovf_o == ovf_sign_rule) else $error("overflow flag wrong"); // R5
    end
    AST_FLAG_EXCL: assert ($onehot0({carry_o, borrow_o, ovf_o})) else $error("flags not exclusive"); // R6
    if (!signed_i) begin
      AST_UNS_VALID: assert (valid_o == (op_sub_i ? (a_i >= b_i) : !ref_add[WIDTH])) else $error("valid wrong"); // R6
    end
  end
endmodule

// File: tb/tb_addsub_flags.sv
module tb_addsub_flags;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [15:0] a, b, res;
  logic        sub, sgn, carry, borrow, ovf, valid;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  addsub_flags dut (
    .a_i(a), .b_i(b), .op_sub_i(sub), .signed_i(sgn),
    .res_o(res), .carry_o(carry), .borrow_o(borrow), .ovf_o(ovf), .valid_o(valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (a=%0d b=%0d sub=%0d sgn=%0d)", tag, act, exp, a, b, sub, sgn);
    end
  endtask

  task automatic run(input int av, input int bv, input bit s_op, input bit s_mode);
    int ures, sa, sb, sres, e_sum, e_c, e_b, e_o;
    @(posedge clk);
    a = 16'(av); b = 16'(bv); sub = s_op; sgn = s_mode;
    @(negedge clk);
    ures  = s_op ? (av - bv) : (av + bv);
    e_sum = ures & 32'hFFFF;
    sa    = (av >= 32768) ? av - 65536 : av;
    sb    = (bv >= 32768) ? bv - 65536 : bv;
    sres  = s_op ? (sa - sb) : (sa + sb);
    e_c   = (!s_mode && !s_op && ures > 65535) ? 1 : 0;
    e_b   = (!s_mode && s_op && av < bv) ? 1 : 0;
    e_o   = (s_mode && (sres > 32767 || sres < -32768)) ? 1 : 0;
    chk(s_op ? "R2 result" : "R1 result", int'(res), e_sum);
    chk("R3 carry", int'(carry), e_c);
    chk("R4 borrow", int'(borrow), e_b);
    chk("R5 overflow", int'(ovf), e_o);
    chk("R6 valid", int'(valid), (e_c | e_b | e_o) ? 0 : 1);
  endtask

  task automatic mode_swap(input int av, input int bv, input bit s_op);
    int r_uns;
    run(av, bv, s_op, 1'b0);
    r_uns = int'(res);
    run(av, bv, s_op, 1'b1);
    chk("R7 mode-independent result", int'(res), r_uns);
  endtask

  initial begin
    a = '0; b = '0; sub = 1'b0; sgn = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset-state result", int'(res), 0);
    chk("R6 reset-state valid", int'(valid), 1);
    // directed list
    run(29, 3, 1, 0);
    run(21, 83, 0, 0);
    run(16800, 16900, 0, 1);
    run(32400, 32200, 0, 1);
    run(8, 52, 1, 0);
    run(103, 145, 1, 0);
    run(202, 97, 0, 0);
    run(6478, 2585, 1, 0);
    run(65534, 65100, 0, 0);
    // boundaries
    run(0, 0, 1, 0);
    run(0, 1, 1, 0);
    run(65535, 1, 0, 0);
    run(65535, 0, 0, 0);
    run(32767, 1, 0, 1);
    run(32768, 1, 1, 1);
    run(32768, 32768, 1, 1);
    run(0, 32768, 1, 1);
    run(65535, 65535, 0, 1);
    run(5, 5, 1, 0);
    mode_swap(32400, 32200, 0);
    mode_swap(8, 52, 1);
    mode_swap(32768, 1, 1);
    // constrained random
    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      int ra, rb;
      ra = int'($urandom & 32'hFFFF);
      rb = int'($urandom & 32'hFFFF);
      if (n % 8 == 0) rb = ra;
      if (n % 8 == 1) ra = ra | 32'h8000;
      run(ra, rb, 1'($urandom), 1'($urandom));
    end
    for (int n = 0; n < 20; n++) begin
      mode_swap(int'($urandom & 32'hFFFF), int'($urandom & 32'hFFFF), 1'(n));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all-requirements act=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule